// File: doc/BRIEF.md
# I2C Master Controller with Byte FIFOs

This block is an I2C bus master that a processor drives through a bank of eight 16-bit registers. Software sets a clock divider, loads the transfer length, and starts a transfer by writing the target address byte with a go bit. The engine then generates the START condition, shifts out the address byte, moves data bytes through a 16-entry transmit queue or a 16-entry receive queue, checks every acknowledge, and closes with STOP. If software asks for it, the engine leaves the bus held for a repeated START instead.

Three event flags report the outcome: done, address refused and data refused. Each flag raises the single interrupt line only while its own enable bit is set. Each queue also has a service-request bit with its own enable, which asks software to refill the transmit queue or drain the receive queue based on the fill level. Both bus lines are open-drain: an output of 1 pulls the line low. When the receive queue is full, the engine parks SCL low until software frees an entry.

Top module: `i2c_fifo_master`

## Requirements
- R1: The divider register (byte offset 0x00) resets to 156, and each SCL period lasts 4 × divider system clocks.
- R2: Writing offset 0x04 with bit 8 set while idle starts a transfer. SDA falls while SCL is high (START), and then bits [7:0] of the written value go out MSB first. Bit 0 is the direction, and 1 means read.
- R3: A write transfer sends length (offset 0x06) bytes taken from the transmit queue (push by writing offset 0x10), ends with SDA rising while SCL is high (STOP), and sets the done flag at bit 8 of offset 0x02.
- R4: A NACK on the address byte sets flag bit 9, leaves bit 8 clear, and ends with STOP.
- R5: A NACK on a data byte sets flag bit 10, leaves bit 8 clear, sends no further bytes, and ends with STOP.
- R6: The interrupt output is high for a flag only while its enable is set. Offset 0x02 bits 0, 1 and 2 enable flags 8, 9 and 10.
- R7: A read transfer stores length bytes in the receive queue, which is popped by reading offset 0x20. The master ACKs every byte except the last, which it NACKs. Bits [5:0] of each queue word (0x18 transmit, 0x28 receive) give the fill level.
- R8: While the receive queue holds 16 bytes during a read, SCL stays low and no byte is lost. The transfer resumes once software pops an entry.
- R9: Status bit 11 is set when the transmit queue enable (bit 15 of 0x18) is on, a write is active, bytes are still owed and the level is below 8. Bit 12 is set when the receive enable (bit 15 of 0x28) is on and the level is at least 8, or when a finished read left bytes in the queue. Either bit drives the interrupt.
- R10: Writing bit 14 of a queue word empties that queue.
- R11: Bit 9 of the start write suppresses STOP: the done flag sets, SCL stays low, and the next transfer begins with a repeated START.
- R12: Writing 1 to a flag bit clears it, and starting a transfer clears all flags. A write of bit 13 to offset 0x04 empties both queues, clears flags and releases the bus, but keeps the divider.
- R13: Within a byte, SDA never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at 0x20) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the receive-full stall, where the engine must hold SCL low in the middle of a read while the target has already driven the next bit. The bench starts a 20-byte read with the queue never drained. It waits until the level reaches 16, lets hundreds of cycles pass to confirm the stall, and then pops entries. The remaining bytes must then arrive intact, with the NACK on the twentieth only. A behavioural open-drain target on the bench side acknowledges or refuses chosen bytes and supplies read data, which also drives the address and data NACK paths and the repeated START after a held bus.

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master #(
  parameter int DEPTH     = 16,
  parameter int DIV_RESET = 156
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_WAIT, S_STOP} st_t;
  st_t st;

  logic [15:0] div_q, len_q, cnt, remain, tx_left;
  logic [2:0]  ien, flg;
  logic [7:0]  adr_q, sh;
  logic        rw_q, nostop_q, hold, err, ackbad, sda_q, is_adr;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic        tx_ien, rx_ien;
  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_div = reg_wr && reg_addr == 6'h00;
  wire wr_cs  = reg_wr && reg_addr == 6'h02;
  wire wr_ac  = reg_wr && reg_addr == 6'h04;
  wire wr_len = reg_wr && reg_addr == 6'h06;
  wire wr_txd = reg_wr && reg_addr == 6'h10;
  wire wr_txs = reg_wr && reg_addr == 6'h18;
  wire wr_rxs = reg_wr && reg_addr == 6'h28;
  wire rd_rxd = reg_rd && reg_addr == 6'h20;

  wire soft_rst = wr_ac && reg_wdata[13];
  wire busy     = st != S_IDLE;
  wire go       = wr_ac && reg_wdata[8] && !soft_rst && !busy;

  wire [15:0] div_eff = (div_q == 16'd0) ? 16'd1 : div_q;
  wire timed = st == S_START || st == S_BYTE || st == S_STOP;
  wire qtick = timed && cnt == div_eff - 16'd1;
  wire wphase = is_adr || !rw_q;
  wire [15:0] nxt_rem = is_adr ? remain : remain - 16'd1;
  wire byte_end = st == S_BYTE && qtick && q == 2'd3 && bitn == 4'd8;

  wire tx_push = wr_txd && tx_cnt != FULL;
  wire tx_pop  = st == S_WAIT && !rw_q && tx_cnt != '0;
  wire rx_push = byte_end && !is_adr && rw_q;
  wire rx_pop  = rd_rxd && rx_cnt != '0;
  wire tx_flush = soft_rst || (wr_txs && reg_wdata[14]);
  wire rx_flush = soft_rst || (wr_rxs && reg_wdata[14]);

  wire tx_req = tx_ien && busy && !rw_q && tx_left != 16'd0 && tx_cnt < HALF;
  wire rx_req = rx_ien && rx_cnt != '0 && (rx_cnt >= HALF || (rw_q && remain == 16'd0));

  wire drive = (bitn < 4'd8) ? (wphase & ~sh[7]) : (!wphase && remain != 16'd1);

  always_comb begin
    case (st)
      S_IDLE:  scl_oe = hold;
      S_START: scl_oe = q == 2'd0 || q == 2'd3;
      S_BYTE:  scl_oe = q < 2'd2;
      S_STOP:  scl_oe = q == 2'd0;
      default: scl_oe = 1'b1;
    endcase
  end
  assign sda_oe = sda_q;
  assign irq = |(flg & ien) | tx_req | rx_req;

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = div_q;
      6'h02:   reg_rdata = {3'b0, rx_req, tx_req, flg, 5'b0, ien};
      6'h04:   reg_rdata = {6'b0, nostop_q, busy, adr_q};
      6'h06:   reg_rdata = len_q;
      6'h18:   reg_rdata = {tx_ien, 9'b0, 6'(tx_cnt)};
      6'h20:   reg_rdata = {8'b0, rx_mem[rx_rp]};
      6'h28:   reg_rdata = {rx_ien, 9'b0, 6'(rx_cnt)};
      default: reg_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= 16'(DIV_RESET); len_q <= '0; ien <= '0;
      adr_q <= '0; rw_q <= 1'b0; nostop_q <= 1'b0;
    end else begin
      if (wr_div) div_q <= reg_wdata;
      if (wr_len) len_q <= reg_wdata;
      if (wr_cs) ien <= reg_wdata[2:0];
      if (go) begin adr_q <= reg_wdata[7:0]; rw_q <= reg_wdata[0]; nostop_q <= reg_wdata[9]; end
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; tx_ien <= 1'b0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_ien <= 1'b0;
      tx_left <= '0;
    end else begin
      if (wr_txs) tx_ien <= reg_wdata[15];
      if (wr_rxs) rx_ien <= reg_wdata[15];
      if (tx_flush) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      end
      if (rx_flush) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
      if (soft_rst) tx_left <= '0;
      else if (go) tx_left <= (!reg_wdata[0] && len_q > 16'(tx_cnt)) ? len_q - 16'(tx_cnt) : 16'd0;
      else if (tx_push && busy && tx_left != 16'd0) tx_left <= tx_left - 16'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; cnt <= '0; bitn <= '0; sh <= '0; is_adr <= 1'b0;
      remain <= '0; ackbad <= 1'b0; err <= 1'b0; hold <= 1'b0; sda_q <= 1'b0; flg <= '0;
    end else if (soft_rst) begin
      st <= S_IDLE; q <= '0; cnt <= '0; bitn <= '0; is_adr <= 1'b0;
      remain <= '0; err <= 1'b0; hold <= 1'b0; sda_q <= 1'b0; flg <= '0;
    end else begin
      if (wr_cs) flg <= flg & ~reg_wdata[10:8];
      if (timed) cnt <= qtick ? 16'd0 : cnt + 16'd1;
      if (go) begin
        st <= S_START; q <= '0; cnt <= '0; sda_q <= 1'b0;
        remain <= len_q; err <= 1'b0; flg <= '0; hold <= 1'b0;
      end
      case (st)
        S_START: if (qtick) begin
          q <= q + 2'd1;
          if (q == 2'd1) sda_q <= 1'b1;
          if (q == 2'd3) begin st <= S_BYTE; sh <= adr_q; bitn <= '0; is_adr <= 1'b1; end
        end
        S_BYTE: if (qtick) begin
          q <= q + 2'd1;
          if (q == 2'd0) sda_q <= drive;
          if (q == 2'd2) begin
            if (bitn < 4'd8) sh <= {sh[6:0], sda_i};
            else ackbad <= sda_i;
          end
          if (q == 2'd3) begin
            if (bitn != 4'd8) bitn <= bitn + 4'd1;
            else if (wphase && ackbad) begin
              st <= S_STOP; sda_q <= 1'b1; err <= 1'b1;
              if (is_adr) flg[1] <= 1'b1; else flg[2] <= 1'b1;
            end else begin
              is_adr <= 1'b0;
              remain <= nxt_rem;
              if (nxt_rem != 16'd0) st <= S_WAIT;
              else if (nostop_q) begin st <= S_IDLE; hold <= 1'b1; flg[0] <= 1'b1; end
              else begin st <= S_STOP; sda_q <= 1'b1; end
            end
          end
        end
        S_WAIT: if (rw_q ? rx_cnt != FULL : tx_cnt != '0) begin
          st <= S_BYTE; q <= '0; cnt <= '0; bitn <= '0;
          if (!rw_q) sh <= tx_mem[tx_rp];
        end
        S_STOP: if (qtick) begin
          q <= q + 2'd1;
          if (q == 2'd1) sda_q <= 1'b0;
          if (q == 2'd3) begin st <= S_IDLE; if (!err) flg[0] <= 1'b1; end
        end
        default: ;
      endcase
    end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && !scl_oe && !$past(scl_oe)) |-> $stable(sda_q)); // R13
  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rw_q && rx_cnt == FULL && !rd_rxd && !soft_rst) |=> st == S_WAIT); // R8
  AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_cnt != FULL); // R8
  AST_DONE_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(flg[0] && (flg[1] || flg[2]))); // R4
  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> flg == 3'b000); // R12
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL); // R7
endmodule

// File: tb/i2c_fifo_master_tb.sv
`timescale 1ns/1ps
module i2c_fifo_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic [5:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic s_pull = 0;
  wire scl_bus = ~scl_oe;
  wire sda_bus = ~(sda_oe | s_pull);

  i2c_fifo_master dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural open-drain target at address 0x50
  int bc = -1, rx_n = 0, nack_at = -1, mack_n = 0, tx_idx = 0, starts = 0, stops = 0;
  logic [7:0] sb = 0, cur = 0, addr_log = 0;
  logic [7:0] rx_log [64];
  logic mack_log [64];
  logic s_addr = 0, s_sel = 0, s_tx = 0, m_nack = 0;
  realtime t_last = 0, t_prev = 0;

  always @(negedge sda_bus) if (scl_bus) begin starts++; bc = -1; s_addr = 1; s_tx = 0; s_pull = 0; end
  always @(posedge sda_bus) if (scl_bus) begin stops++; bc = -1; s_sel = 0; s_tx = 0; s_pull = 0; end
  always @(posedge scl_bus) begin
    t_prev = t_last; t_last = $realtime;
    if (bc >= 0 && bc < 8 && !s_tx) sb = {sb[6:0], sda_bus};
    else if (bc == 8 && s_tx) begin mack_log[mack_n] = ~sda_bus; mack_n++; m_nack = sda_bus; end
  end
  always @(negedge scl_bus) begin
    if (bc < 0) bc = 0;
    else if (bc < 8) begin
      bc++;
      if (bc == 8) begin
        if (s_tx) s_pull = 0;
        else if (s_addr) begin addr_log = sb; s_sel = (sb[7:1] == 7'h50); s_pull = s_sel; end
        else if (s_sel) begin rx_log[rx_n] = sb; s_pull = (rx_n != nack_at); rx_n++; end
      end else if (s_tx) s_pull = ~cur[7 - bc];
    end else begin
      bc = 0; s_pull = 0;
      if (s_addr) begin s_addr = 0; s_tx = s_sel && sb[0]; end
      else if (s_tx && m_nack) s_tx = 0;
      if (s_tx) begin cur = 8'h10 + 8'(tx_idx); tx_idx++; s_pull = ~cur[7]; end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin fails++; $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp); end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, bit pop, output logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_rd = pop; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle(string req);
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(6'h04, 0, v);
      if (!v[8]) return;
    end
    chk(req, 1, 0);
  endtask

  task automatic clr_log();
    rx_n = 0; mack_n = 0; tx_idx = 0; nack_at = -1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(6'h00, 0, v); chk("R1 divider reset", v, 156);
    rd(6'h02, 0, v); chk("R12 status reset", v, 0);
    rd(6'h18, 0, v); chk("R7 tx level reset", v, 0);
    rd(6'h28, 0, v); chk("R7 rx level reset", v, 0);
    chk("R6 irq reset", irq, 0);
    chk("R11 bus released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write();
    logic [15:0] v; int s0, p0;
    clr_log(); s0 = starts; p0 = stops;
    wr(6'h00, 4);
    wr(6'h10, 16'h00A5); wr(6'h10, 16'h003C); wr(6'h10, 16'h0081);
    wr(6'h06, 3); wr(6'h02, 16'h0001);
    wr(6'h04, 16'h0100 | 16'hA0);
    wait (rx_n == 1);
    chk("R1 scl period", int'(t_last - t_prev), 64);
    wait_idle("R3 write timeout");
    chk("R2 address byte", addr_log, 8'hA0);
    chk("R3 byte count", rx_n, 3);
    chk("R3 byte0", rx_log[0], 8'hA5);
    chk("R3 byte1", rx_log[1], 8'h3C);
    chk("R3 byte2", rx_log[2], 8'h81);
    rd(6'h02, 0, v); chk("R3 done flag", v[10:8], 3'b001);
    chk("R6 irq enabled done", irq, 1);
    chk("R13 start count", starts - s0, 1);
    chk("R13 stop count", stops - p0, 1);
    wr(6'h02, 16'h0100);
    rd(6'h02, 0, v); chk("R12 w1c clears done", v[10:8], 0);
    chk("R12 irq after w1c", irq, 0);
  endtask

  task automatic t_anack();
    logic [15:0] v; int p0;
    clr_log(); p0 = stops;
    wr(6'h02, 16'h0001);
    wr(6'h06, 2); wr(6'h04, 16'h0100 | 16'h66);
    wait_idle("R4 timeout");
    rd(6'h02, 0, v); chk("R4 addr nack flag", v[10:8], 3'b010);
    chk("R4 stop sent", stops - p0, 1);
    chk("R6 irq masked", irq, 0);
    wr(6'h02, 16'h0002);
    chk("R6 irq unmasked", irq, 1);
    wr(6'h02, 16'h0200);
  endtask

  task automatic t_dnack();
    logic [15:0] v; int p0;
    clr_log(); p0 = stops; nack_at = 1;
    wr(6'h02, 16'h0004);
    wr(6'h10, 16'h11); wr(6'h10, 16'h22); wr(6'h10, 16'h33);
    wr(6'h06, 3); wr(6'h04, 16'h0100 | 16'hA0);
    wait_idle("R5 timeout");
    rd(6'h02, 0, v); chk("R5 data nack flag", v[10:8], 3'b100);
    chk("R5 bytes on bus", rx_n, 2);
    chk("R5 stop sent", stops - p0, 1);
    chk("R6 irq data nack", irq, 1);
    wr(6'h18, 16'h4000); wr(6'h02, 16'h0400);
  endtask

  task automatic t_read();
    logic [15:0] v;
    clr_log();
    wr(6'h02, 16'h0000); wr(6'h28, 16'h8000);
    wr(6'h06, 5); wr(6'h04, 16'h0100 | 16'hA1);
    wait_idle("R7 timeout");
    rd(6'h28, 0, v); chk("R7 rx level", v[5:0], 5);
    rd(6'h02, 0, v); chk("R9 rx req at end", v[12], 1);
    chk("R9 irq from rx req", irq, 1);
    chk("R7 master ack count", mack_n, 5);
    for (int i = 0; i < 5; i++) chk("R7 master ack bit", mack_log[i], i != 4);
    for (int i = 0; i < 5; i++) begin rd(6'h20, 1, v); chk("R7 read byte", v[7:0], 8'h10 + 8'(i)); end
    rd(6'h02, 0, v); chk("R9 rx req after drain", v[12], 0);
    wr(6'h28, 16'h0000);
  endtask

  task automatic t_rxfull();
    logic [15:0] v;
    clr_log();
    wr(6'h06, 20); wr(6'h04, 16'h0100 | 16'hA1);
    for (int i = 0; i < 30000; i++) begin rd(6'h28, 0, v); if (v[5:0] == 16) break; end
    repeat (600) @(negedge clk);
    rd(6'h28, 0, v); chk("R8 held at full", v[5:0], 16);
    rd(6'h04, 0, v); chk("R8 still busy", v[8], 1);
    chk("R8 scl held low", scl_oe, 1);
    for (int i = 0; i < 16; i++) begin rd(6'h20, 1, v); chk("R8 byte before stall", v[7:0], 8'h10 + 8'(i)); end
    wait_idle("R8 timeout");
    rd(6'h28, 0, v); chk("R8 tail level", v[5:0], 4);
    for (int i = 16; i < 20; i++) begin rd(6'h20, 1, v); chk("R8 byte after stall", v[7:0], 8'h10 + 8'(i)); end
    chk("R7 last nacked", mack_log[19], 0);
    chk("R7 prior acked", mack_log[18], 1);
  endtask

  task automatic t_txreq();
    logic [15:0] v;
    clr_log();
    wr(6'h18, 16'h8000); wr(6'h02, 0);
    wr(6'h06, 10); wr(6'h04, 16'h0100 | 16'hA0);
    rd(6'h02, 0, v); chk("R9 tx req while owed", v[11], 1);
    chk("R9 irq from tx req", irq, 1);
    for (int i = 0; i < 10; i++) wr(6'h10, 16'(8'h40 + i));
    rd(6'h02, 0, v); chk("R9 tx req cleared", v[11], 0);
    wait_idle("R9 timeout");
    chk("R3 streamed count", rx_n, 10);
    chk("R3 streamed last", rx_log[9], 8'h49);
    wr(6'h18, 0);
  endtask

  task automatic t_flush();
    logic [15:0] v;
    wr(6'h10, 1); wr(6'h10, 2); wr(6'h10, 3);
    rd(6'h18, 0, v); chk("R7 tx level", v[5:0], 3);
    wr(6'h18, 16'h4000);
    rd(6'h18, 0, v); chk("R10 tx flushed", v[5:0], 0);
  endtask

  task automatic t_nostop();
    logic [15:0] v; int s0, p0;
    clr_log(); s0 = starts; p0 = stops;
    wr(6'h10, 16'h5A); wr(6'h06, 1);
    wr(6'h04, 16'h0300 | 16'hA0);
    wait_idle("R11 timeout");
    rd(6'h02, 0, v); chk("R11 done flag", v[10:8], 3'b001);
    chk("R11 no stop", stops - p0, 0);
    chk("R11 scl held low", scl_oe, 1);
    wr(6'h10, 16'hC3); wr(6'h04, 16'h0100 | 16'hA0);
    wait_idle("R11 second timeout");
    chk("R11 repeated start", starts - s0, 2);
    chk("R11 final stop", stops - p0, 1);
    chk("R11 second byte", rx_log[1], 8'hC3);
  endtask

  task automatic t_softreset();
    logic [15:0] v;
    wr(6'h06, 1); wr(6'h04, 16'h0100 | 16'h22);
    wait_idle("R12 timeout");
    wr(6'h10, 7); wr(6'h10, 8);
    wr(6'h04, 16'h2000);
    rd(6'h02, 0, v); chk("R12 flags after soft reset", v[10:8], 0);
    rd(6'h18, 0, v); chk("R12 tx emptied", v[5:0], 0);
    rd(6'h00, 0, v); chk("R12 divider kept", v, 4);
    chk("R12 bus released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_write(); t_anack(); t_dnack(); t_read();
    t_rxfull(); t_txreq(); t_flush(); t_nostop(); t_softreset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule